// File: doc/BRIEF.md
# Store Buffer with Invalidate-Gated Retirement and Forwarding

This block sits between one core's store port and that core's private cache in a small coherent system. A store that touches a line other caches may hold is parked in a small in-order queue. On the cycle the store is parked, an invalidate request for its line is sent to every peer cache. The core is not held up by this. A parked entry is written into the local cache only once every peer has acknowledged its invalidate. Each entry keeps its address, data, byte enables and a count of acknowledgements still owed. That count starts at the number of peers.

Loads look up the queue combinationally and get, byte by byte, the youngest parked data for their word. The core merges this result with what the cache returns. A store to a line the core already holds exclusively needs no invalidate. If no parked entry covers the same word, that store goes straight to the cache and can become visible before older parked stores. A write-barrier request holds back every later store until the queue has drained. A busy flag reports when such a barrier is waiting.

Top module: `store_buf_top`

## Requirements
- R1: After reset the queue is empty. `st_ready` is high, and `wbar_busy`, `cw_valid`, `inv_valid` and `ld_fwd_be` are all low.
- R2: A store is "shared" when `st_excl` is 0. An accepted shared store takes a queue slot and raises `inv_valid` in the same cycle. `inv_line` is `st_addr` with its low `LINE_OFF_W` bits dropped, and `inv_tag` is the slot index. Slots are handed out round-robin, starting at 0 after reset. While slots are free, `st_ready` stays high no matter how many acknowledgements are outstanding.
- R3: A parked entry appears on the cache write port no earlier than the cycle after the last of its `NPEER` acknowledgements arrives. If it is at the head of the queue, it appears exactly in that cycle. A peer acknowledges by pulsing its bit of `ack_valid` with the slot index in its field of `ack_tag`; peer p uses bits [p*IDX_W +: IDX_W].
- R4: Parked entries are written to the cache strictly in the order they were accepted, with their own address, data and byte enables.
- R5: For `ld_addr`, each byte lane of `ld_fwd_data` carries the data of the youngest parked entry for that word whose byte enable covers the lane, and the matching bit of `ld_fwd_be` is set. Lanes that no entry covers read 0, and their `ld_fwd_be` bit is clear.
- R6: When all `DEPTH` slots are occupied, `st_ready` is low for any store that needs a slot.
- R7: `wbar_req` with a non-empty queue raises `wbar_busy` from the next cycle. `wbar_busy` falls on the clock edge where the queue becomes empty. While `wbar_busy` is high, and in the request cycle itself, `st_ready` is low.
- R8: `wbar_req` with an empty queue leaves `wbar_busy` low and does not stall a store in the same cycle.
- R9: An exclusive store (`st_excl`=1) whose word is not parked bypasses the queue. It is written on the cache write port in the cycle it is accepted, raises no invalidate, and may overtake older parked stores.
- R10: An exclusive store whose word is already parked is itself parked behind it, with no invalidate and no acknowledgement owed. It is written in queue order.
- R11: The cache write port carries at most one write per cycle. A head retirement has priority, so an exclusive bypass store sees `st_ready` low in a cycle where the head retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store request valid |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_excl | input | 1 | Line is held exclusively in the local cache |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| wbar_req | input | 1 | Write-barrier request, one-cycle pulse |
| wbar_busy | output | 1 | A barrier is waiting for the queue to drain |
| ld_addr | input | ADDR_W | Load word address for the forwarding lookup |
| ld_fwd_be | output | DATA_W/8 | Byte lanes supplied by the queue |
| ld_fwd_data | output | DATA_W | Forwarded data, zero in lanes not supplied |
| inv_valid | output | 1 | Invalidate request to all peers |
| inv_line | output | ADDR_W-LINE_OFF_W | Line address being invalidated |
| inv_tag | output | IDX_W | Slot index the acknowledgements must return |
| ack_valid | input | NPEER | One acknowledgement pulse per peer |
| ack_tag | input | NPEER*IDX_W | Slot index of each peer's acknowledgement |
| cw_valid | output | 1 | Cache write strobe |
| cw_addr | output | ADDR_W | Cache write word address |
| cw_data | output | DATA_W | Cache write data |
| cw_be | output | DATA_W/8 | Cache write byte enables |

## Verification
The hardest situation to reach is an exclusive store arriving in the very cycle the head entry has just collected its last acknowledgement. In that cycle the port conflict must stall the bypass store and nothing else. The bench tracks every outstanding acknowledgement in its own model. It waits until the head owes none, and only then offers an exclusive store to a fresh word, so the collision happens on a known cycle. Early retirement, barrier ordering and overtaking are reached by holding all peer acknowledgements back for a while and releasing them later with random delays. Meanwhile a sweep over every byte-enable pattern and a small set of colliding addresses exercises the per-lane forwarding.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Source selected for the single cache write port in a cycle.
  typedef enum logic [1:0] {
    CW_IDLE   = 2'd0,
    CW_RETIRE = 2'd1,
    CW_BYPASS = 2'd2
  } cw_src_e;

endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/sb_ack_track.sv
module sb_ack_track #(
  parameter int DEPTH = 4,
  parameter int NPEER = 2,
  parameter int IDX_W = 2,
  parameter int ACK_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_en,
  input  logic [IDX_W-1:0]             alloc_idx,
  input  logic [ACK_W-1:0]             alloc_cnt,
  input  logic [NPEER-1:0]             ack_valid,
  input  logic [NPEER*IDX_W-1:0]       ack_tag,
  output logic [DEPTH-1:0][ACK_W-1:0]  owed
);

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [ACK_W-1:0] hits;
    logic [ACK_W-1:0] owed_n;
    logic             owed_en;

    always_comb begin
      hits = '0;
      for (int p = 0; p < NPEER; p++) begin
        if (ack_valid[p] && (ack_tag[p*IDX_W +: IDX_W] == IDX_W'(j)))
          hits = hits + 1'b1;
      end
    end

    always_comb begin
      owed_en = 1'b0;
      owed_n  = owed[j];
      if (alloc_en && (alloc_idx == IDX_W'(j))) begin
        owed_en = 1'b1;
        owed_n  = alloc_cnt;
      end else if (hits != '0) begin
        owed_en = 1'b1;
        owed_n  = (hits > owed[j]) ? '0 : owed[j] - hits;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       owed[j] <= '0;
      else if (owed_en) owed[j] <= owed_n;
    end
  end

endmodule

// File: rtl/sb_fwd_merge.sv
module sb_fwd_merge #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  localparam int NB    = DATA_W / 8
) (
  input  logic [IDX_W-1:0]              head,
  input  logic [DEPTH-1:0]              e_vld,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  e_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0]  e_data,
  input  logic [DEPTH-1:0][NB-1:0]      e_be,
  input  logic [ADDR_W-1:0]             ld_addr,
  output logic [NB-1:0]                 ld_be,
  output logic [DATA_W-1:0]             ld_data
);

  // Walk oldest to youngest so a younger entry overwrites each lane it covers.
  always_comb begin
    logic [IDX_W-1:0] idx;
    ld_be   = '0;
    ld_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = IDX_W'((32'(head) + 32'(k)) % 32'(DEPTH));
      if (e_vld[idx] && (e_addr[idx] == ld_addr)) begin
        for (int b = 0; b < NB; b++) begin
          if (e_be[idx][b]) begin
            ld_be[b]          = 1'b1;
            ld_data[b*8 +: 8] = e_data[idx][b*8 +: 8];
          end
        end
      end
    end
  end

endmodule

// File: rtl/store_buf_top.sv
module store_buf_top #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 4,
  parameter int NPEER      = 2,
  parameter int LINE_OFF_W = 2,
  localparam int NB        = DATA_W / 8,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int LINE_W    = ADDR_W - LINE_OFF_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   st_valid,
  input  logic [ADDR_W-1:0]      st_addr,
  input  logic [DATA_W-1:0]      st_data,
  input  logic [NB-1:0]          st_be,
  input  logic                   st_excl,
  output logic                   st_ready,
  input  logic                   wbar_req,
  output logic                   wbar_busy,
  input  logic [ADDR_W-1:0]      ld_addr,
  output logic [NB-1:0]          ld_fwd_be,
  output logic [DATA_W-1:0]      ld_fwd_data,
  output logic                   inv_valid,
  output logic [LINE_W-1:0]      inv_line,
  output logic [IDX_W-1:0]       inv_tag,
  input  logic [NPEER-1:0]       ack_valid,
  input  logic [NPEER*IDX_W-1:0] ack_tag,
  output logic                   cw_valid,
  output logic [ADDR_W-1:0]      cw_addr,
  output logic [DATA_W-1:0]      cw_data,
  output logic [NB-1:0]          cw_be
);
  import sb_pkg::*;

  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int ACK_W = $clog2(NPEER + 1);

  function automatic logic [IDX_W-1:0] ptr_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic                          rst_q_n;
  logic [DEPTH-1:0]              e_vld, e_vld_n;
  logic [DEPTH-1:0][ADDR_W-1:0]  e_addr;
  logic [DEPTH-1:0][DATA_W-1:0]  e_data;
  logic [DEPTH-1:0][NB-1:0]      e_be;
  logic [DEPTH-1:0][ACK_W-1:0]   ack_owed;
  logic [IDX_W-1:0]              head, head_n, tail, tail_n;
  logic [OCC_W-1:0]              occ, occ_n;
  logic                          bar_pend, bar_pend_n;
  logic                          q_empty, q_full, st_match, retire;
  logic                          bar_block, bypass, acc, alloc;
  logic [ACK_W-1:0]              alloc_cnt;
  cw_src_e                       cw_src;

  sb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  sb_ack_track #(
    .DEPTH (DEPTH),
    .NPEER (NPEER),
    .IDX_W (IDX_W),
    .ACK_W (ACK_W)
  ) u_ack (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .alloc_en  (alloc),
    .alloc_idx (tail),
    .alloc_cnt (alloc_cnt),
    .ack_valid (ack_valid),
    .ack_tag   (ack_tag),
    .owed      (ack_owed)
  );

  sb_fwd_merge #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_fwd (
    .head    (head),
    .e_vld   (e_vld),
    .e_addr  (e_addr),
    .e_data  (e_data),
    .e_be    (e_be),
    .ld_addr (ld_addr),
    .ld_be   (ld_fwd_be),
    .ld_data (ld_fwd_data)
  );

  // Acceptance and routing decisions.
  always_comb begin
    st_match = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (e_vld[i] && (e_addr[i] == st_addr)) st_match = 1'b1;
    end
  end

  assign q_empty   = (occ == '0);
  assign q_full    = (occ == OCC_W'(DEPTH));
  assign retire    = e_vld[head] && (ack_owed[head] == '0);
  assign bar_block = bar_pend || (wbar_req && !q_empty);
  assign bypass    = st_excl && !st_match;
  assign st_ready  = !bar_block && (bypass ? !retire : !q_full);
  assign acc       = st_valid && st_ready;
  assign alloc     = acc && !bypass;
  assign alloc_cnt = st_excl ? '0 : ACK_W'(NPEER);

  assign inv_valid = alloc && !st_excl;
  assign inv_line  = st_addr[ADDR_W-1:LINE_OFF_W];
  assign inv_tag   = tail;
  assign wbar_busy = bar_pend;

  // Single cache write port: the head retirement wins over a bypass store.
  always_comb begin
    cw_src = CW_IDLE;
    if (retire)             cw_src = CW_RETIRE;
    else if (acc && bypass) cw_src = CW_BYPASS;
  end

  always_comb begin
    cw_valid = 1'b0;
    cw_addr  = st_addr;
    cw_data  = st_data;
    cw_be    = st_be;
    case (cw_src)
      CW_RETIRE: begin
        cw_valid = 1'b1;
        cw_addr  = e_addr[head];
        cw_data  = e_data[head];
        cw_be    = e_be[head];
      end
      CW_BYPASS: cw_valid = 1'b1;
      default:   cw_valid = 1'b0;
    endcase
  end

  // Next state of the queue control.
  always_comb begin
    head_n = retire ? ptr_inc(head) : head;
    tail_n = alloc  ? ptr_inc(tail) : tail;
    occ_n  = occ + OCC_W'(alloc) - OCC_W'(retire);
    for (int i = 0; i < DEPTH; i++) begin
      e_vld_n[i] = e_vld[i];
      if (retire && (head == IDX_W'(i))) e_vld_n[i] = 1'b0;
      if (alloc  && (tail == IDX_W'(i))) e_vld_n[i] = 1'b1;
    end
    bar_pend_n = (bar_pend || (wbar_req && !q_empty)) && (occ_n != '0);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      e_vld    <= '0;
      head     <= '0;
      tail     <= '0;
      occ      <= '0;
      bar_pend <= 1'b0;
    end else begin
      e_vld    <= e_vld_n;
      head     <= head_n;
      tail     <= tail_n;
      occ      <= occ_n;
      bar_pend <= bar_pend_n;
    end
  end

  // Entry payload: no reset, written only with the slot's enable.
  for (genvar i = 0; i < DEPTH; i++) begin : g_pay
    logic wr_en;
    assign wr_en = alloc && (tail == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        e_addr[i] <= st_addr;
        e_data[i] <= st_data;
        e_be[i]   <= st_be;
      end
    end
  end

endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
  parameter int DEPTH = 4,
  parameter int NPEER = 2,
  parameter int IDX_W = 2,
  parameter int OCC_W = 3,
  parameter int ACK_W = 2
) (
  input logic                   clk,
  input logic                   rst_q_n,
  input logic                   st_valid,
  input logic                   st_excl,
  input logic                   st_ready,
  input logic                   inv_valid,
  input logic [IDX_W-1:0]       inv_tag,
  input logic [NPEER-1:0]       ack_valid,
  input logic [NPEER*IDX_W-1:0] ack_tag,
  input logic                   retire,
  input logic                   alloc,
  input logic                   bypass,
  input logic [IDX_W-1:0]       head,
  input logic [IDX_W-1:0]       tail,
  input logic [OCC_W-1:0]       occ,
  input logic                   wbar_busy
);

  // Independent tally of acknowledgements still owed per slot.
  logic [DEPTH-1:0][ACK_W-1:0] need;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      need <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        logic [ACK_W-1:0] v;
        v = need[j];
        for (int p = 0; p < NPEER; p++) begin
          if (ack_valid[p] && (ack_tag[p*IDX_W +: IDX_W] == IDX_W'(j)) && (v != '0))
            v = v - 1'b1;
        end
        if (alloc && (tail == IDX_W'(j))) v = inv_valid ? ACK_W'(NPEER) : '0;
        need[j] <= v;
      end
    end
  end

  p_inv_from_store_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    inv_valid |-> (st_valid && st_ready && !st_excl && (inv_tag == tail)));

  p_no_early_retire_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    retire |-> (need[head] == '0));

  p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (occ == OCC_W'(DEPTH) && st_valid && !bypass) |-> !st_ready);

  p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    occ <= OCC_W'(DEPTH));

  p_bar_blocks_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    wbar_busy |-> (!st_ready && (occ != '0)));

  p_bar_clear_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(wbar_busy) |-> (occ == '0));

  p_bypass_quiet_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_valid && st_ready && bypass) |-> !inv_valid);

  p_port_priority_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (retire && st_valid && bypass) |-> !st_ready);

endmodule

bind store_buf_top sb_chk #(
  .DEPTH (DEPTH),
  .NPEER (NPEER),
  .IDX_W (IDX_W),
  .OCC_W (OCC_W),
  .ACK_W (ACK_W)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .st_valid  (st_valid),
  .st_excl   (st_excl),
  .st_ready  (st_ready),
  .inv_valid (inv_valid),
  .inv_tag   (inv_tag),
  .ack_valid (ack_valid),
  .ack_tag   (ack_tag),
  .retire    (retire),
  .alloc     (alloc),
  .bypass    (bypass),
  .head      (head),
  .tail      (tail),
  .occ       (occ),
  .wbar_busy (wbar_busy)
);

// File: tb/store_buf_top_tb_top.sv
module store_buf_top_tb_top;

  localparam int ADDR_W = 12, DATA_W = 32, DEPTH = 4, NPEER = 2, LOFF = 2;
  localparam int NB = DATA_W / 8, IDX_W = 2;

  logic clk, rst_n;
  logic st_valid, st_excl, st_ready, wbar_req, wbar_busy;
  logic [ADDR_W-1:0] st_addr, ld_addr, cw_addr;
  logic [DATA_W-1:0] st_data, ld_fwd_data, cw_data;
  logic [NB-1:0] st_be, ld_fwd_be, cw_be;
  logic inv_valid, cw_valid;
  logic [ADDR_W-LOFF-1:0] inv_line;
  logic [IDX_W-1:0] inv_tag;
  logic [NPEER-1:0] ack_valid;
  logic [NPEER*IDX_W-1:0] ack_tag;

  store_buf_top dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct { logic [ADDR_W-1:0] a; logic [DATA_W-1:0] d; logic [NB-1:0] be; int tag; int need; } ent_t;
  typedef struct { int peer; int tag; int due; } ackr_t;

  ent_t  q[$];
  ackr_t aq[$];
  int cyc = 0, n_chk = 0, n_bad = 0, tail_m = 0, ack_max = 6;
  bit bar_m = 0, hold = 0, last_acc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    int acked [NPEER];
    bit retire_e, match, byp, bb, rdy_e, acc, inv_e;
    logic [NB-1:0] xbe; logic [DATA_W-1:0] xd;
    string rq;
    int sz0;
    @(negedge clk);
    ack_valid = '0;
    for (int p = 0; p < NPEER; p++) begin
      acked[p] = -1;
      if (!hold) begin
        for (int i = 0; i < aq.size(); i++) begin
          if (aq[i].peer == p && aq[i].due <= cyc) begin
            ack_valid[p] = 1'b1;
            ack_tag[p*IDX_W +: IDX_W] = IDX_W'(aq[i].tag);
            acked[p] = aq[i].tag;
            aq.delete(i);
            break;
          end
        end
      end
    end
    #1;
    retire_e = (q.size() > 0) && (q[0].need == 0);
    match = 0;
    foreach (q[i]) if (q[i].a == st_addr) match = 1;
    byp = st_excl && !match;
    bb = bar_m || (wbar_req && q.size() > 0);
    rdy_e = !bb && (byp ? !retire_e : (q.size() < DEPTH));
    if (bb) rq = "R7";
    else if (wbar_req) rq = "R8";
    else if (byp && retire_e) rq = "R11";
    else if (byp) rq = "R9";
    else if (q.size() == DEPTH) rq = "R6";
    else rq = "R2";
    if (st_valid) chk(st_ready == rdy_e, rq, "st_ready", 64'(st_ready), 64'(rdy_e));
    acc = st_valid && rdy_e;
    last_acc = acc;
    // cache write port
    if (retire_e)
      chk({cw_valid, cw_addr, cw_data, cw_be} == {1'b1, q[0].a, q[0].d, q[0].be}, "R4",
          "retire write", {cw_valid, cw_addr, cw_data, cw_be}, {1'b1, q[0].a, q[0].d, q[0].be});
    else if (acc && byp)
      chk({cw_valid, cw_addr, cw_data, cw_be} == {1'b1, st_addr, st_data, st_be}, "R9",
          "bypass write", {cw_valid, cw_addr, cw_data, cw_be}, {1'b1, st_addr, st_data, st_be});
    else
      chk(cw_valid == 1'b0, "R3", "write before all acks", 64'(cw_valid), 64'(0));
    // invalidate
    inv_e = acc && !byp && !st_excl;
    chk(inv_valid == inv_e, (st_excl && match) ? "R10" : "R2", "inv_valid", 64'(inv_valid), 64'(inv_e));
    if (inv_e)
      chk({inv_line, inv_tag} == {st_addr[ADDR_W-1:LOFF], IDX_W'(tail_m)}, "R2", "inv line/tag",
          {inv_line, inv_tag}, {st_addr[ADDR_W-1:LOFF], IDX_W'(tail_m)});
    // forwarding
    xbe = '0; xd = '0;
    foreach (q[i]) if (q[i].a == ld_addr)
      for (int b = 0; b < NB; b++) if (q[i].be[b]) begin xbe[b] = 1'b1; xd[b*8 +: 8] = q[i].d[b*8 +: 8]; end
    chk({ld_fwd_be, ld_fwd_data} == {xbe, xd}, "R5", "forward", {ld_fwd_be, ld_fwd_data}, {xbe, xd});
    chk(wbar_busy == bar_m, "R7", "wbar_busy", 64'(wbar_busy), 64'(bar_m));
    // model update for the coming edge
    sz0 = q.size();
    if (retire_e) void'(q.pop_front());
    for (int p = 0; p < NPEER; p++)
      if (acked[p] >= 0)
        foreach (q[i]) if (q[i].tag == acked[p] && q[i].need > 0) begin q[i].need--; break; end
    if (acc && !byp) begin
      q.push_back('{st_addr, st_data, st_be, tail_m, st_excl ? 0 : NPEER});
      if (!st_excl)
        for (int p = 0; p < NPEER; p++)
          aq.push_back('{p, tail_m, cyc + 1 + int'($urandom_range(0, ack_max))});
      tail_m = (tail_m + 1) % DEPTH;
    end
    bar_m = (bar_m || (wbar_req && sz0 > 0)) && (q.size() > 0);
    cyc++;
    @(posedge clk); #1;
  endtask

  task automatic set_st(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic [NB-1:0] be, input bit ex);
    st_addr = a; st_data = d; st_be = be; st_excl = ex; st_valid = 1'b1;
  endtask

  task automatic store_wait();
    do step(); while (!last_acc);
    st_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0 || aq.size() > 0) step();
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] aset [6];
    aset = '{12'h010, 12'h011, 12'h014, 12'h020, 12'h021, 12'h3fc};
    rst_n = 1'b0; st_valid = 0; st_excl = 0; st_addr = '0; st_data = '0; st_be = '0;
    wbar_req = 0; ld_addr = '0; ack_valid = '0; ack_tag = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({st_ready, wbar_busy, cw_valid, inv_valid, ld_fwd_be} == {1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, "R1",
        "reset state", {st_ready, wbar_busy, cw_valid, inv_valid, ld_fwd_be}, {1'b1, 1'b0, 1'b0, 1'b0, 4'h0});
    @(posedge clk); #1;

    // Sweep: every byte mask over colliding addresses, mixed exclusive stores.
    for (int be = 1; be < 16; be++)
      for (int i = 0; i < 6; i++) begin
        ld_addr = aset[(i + be) % 6];
        set_st(aset[i], 32'(be * 32'h01030507 + i * 32'h11000000), 4'(be), ((be + i) % 5) == 0);
        store_wait();
      end
    drain();

    // R6: fill with acks withheld, then a further shared store must wait.
    hold = 1;
    for (int i = 0; i < DEPTH; i++) begin set_st(12'h100 + 12'(i), 32'hA0 + 32'(i), 4'hF, 0); store_wait(); end
    set_st(12'h140, 32'hBEEF, 4'h3, 0);
    repeat (3) step();
    hold = 0;
    store_wait();
    drain();

    // R7: barrier behind two parked stores, a younger store must wait for drain.
    hold = 1;
    set_st(12'h200, 32'h1111_2222, 4'hF, 0); store_wait();
    set_st(12'h204, 32'h3333_4444, 4'hC, 0); store_wait();
    set_st(12'h208, 32'h5555_6666, 4'hF, 1);
    wbar_req = 1'b1; step(); wbar_req = 1'b0;
    repeat (4) step();
    hold = 0;
    store_wait();
    drain();

    // R8: barrier on an empty queue with a store in the same cycle.
    set_st(12'h300, 32'h0BAD_F00D, 4'h5, 0);
    wbar_req = 1'b1; step(); wbar_req = 1'b0; st_valid = 1'b0;
    repeat (2) step();
    drain();

    // R9: exclusive store overtakes a parked shared store; load sees the parked one.
    hold = 1;
    set_st(12'h400, 32'hCAFE_0001, 4'hF, 0); store_wait();
    ld_addr = 12'h400;
    set_st(12'h404, 32'hCAFE_0002, 4'hF, 1); store_wait();
    step();
    hold = 0;
    drain();

    // R10: exclusive store to a parked word stays behind it; lanes merge.
    hold = 1;
    set_st(12'h500, 32'h1122_3344, 4'hF, 0); store_wait();
    ld_addr = 12'h500;
    set_st(12'h500, 32'hAA00_BB00, 4'hA, 1); store_wait();
    step();
    hold = 0;
    drain();

    // R11: exclusive bypass offered exactly when the head becomes ready.
    ack_max = 0;
    set_st(12'h600, 32'h6060_6060, 4'hF, 0); store_wait();
    while (q.size() > 0 && q[0].need != 0) step();
    set_st(12'h604, 32'h7070_7070, 4'hF, 1);
    store_wait();
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule